// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a single-channel SPI master that software drives through a small 32-bit register bus with a write strobe and an always-valid read path. Software picks a peripheral and asserts its select line through the control register, sets clock polarity, clock phase and word size in the configuration register, then writes a word to the data-out register. That write starts one full-duplex exchange of 8 or 16 bits. When the last bit has been captured, the word received from the peripheral lands in the data-in register and the interrupt-cause register becomes nonzero. Software clears the cause register before the next word.

The serial clock rate comes from a separate divider. It delivers one-cycle `sck_tick` pulses, and each pulse moves SCK by one edge. A timing register holds a two-bit MISO sample-delay field. Its value 2 moves every capture one system clock later than the nominal capture edge, which helps with fast peripherals in mode 3.

Top module: `spi_host_top`

## Requirements
- R1: After reset every select line is high, SCK and MOSI are low, the timing register reads 0x00000040 and every other register reads zero.
- R2: Control register (offset 0x00): bits [4:2] hold the select index and bit 0 asserts the select. When bit 0 is set, only `cs_n[index]` is low. When bit 0 is clear, all select lines are high.
- R3: Configuration register (offset 0x04): bit 11 is CPOL and gives the SCK level while no exchange runs; bit 12 is CPHA; bit 5 set selects 16-bit words and clear selects 8-bit words.
- R4: A write to data-out (offset 0x08) while idle starts an exchange of 2·N SCK edges, with N the word size, one edge per `sck_tick`. MOSI carries the word MSB first. With CPHA=0 bits are captured on leading edges and changed on trailing edges. With CPHA=1 they are changed on leading edges and captured on trailing edges.
- R5: After an exchange, data-in (offset 0x0C) holds the N bits received on MISO, MSB first, right-aligned with zeros above. In 8-bit mode only bits [7:0] of the written word are sent.
- R6: Interrupt cause (offset 0x10) reads 1 in bit 0 once an exchange completes, and any write to it clears it.
- R7: A write to data-out while an exchange runs is ignored: the running exchange, its received word and the data-out readback are unchanged.
- R8: Timing register (offset 0x18) bits [7:6] set the MISO sample delay: value 2 captures each bit one system clock after its capture edge, and any other value captures on the edge itself.
- R9: Register bits with no function read zero: control reads only bits 4:2 and 0, configuration only bits 12, 11 and 5, timing only bits 7:6, data-out only bits 15:0, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sck_tick | input | 1 | One-cycle pulse from the rate divider; moves SCK one edge |
| miso | input | 1 | Serial data from the peripheral |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| cs_n | output | 8 | Active-low peripheral selects |

## Verification
The in-RTL assertions check on every cycle that SCK rests at the CPOL level and MOSI stays low between exchanges, that all selects are released when the assert bit is clear, that a completed exchange raises the cause register, and that a data-out write during an exchange leaves the held word alone. Only the bench's scenarios can show the serial behaviour itself: MSB-first order in all four clock modes and both word sizes, the received word in data-in, and the effect of the late sample point. The bench shows the sample point with a peripheral model that flips MISO half a clock after each capture edge, so the late setting must return the inverted word.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

   // register byte offsets
   localparam int unsigned OFS_CTRL  = 32'h00;
   localparam int unsigned OFS_CFG   = 32'h04;
   localparam int unsigned OFS_DOUT  = 32'h08;
   localparam int unsigned OFS_DIN   = 32'h0C;
   localparam int unsigned OFS_CAUSE = 32'h10;
   localparam int unsigned OFS_TIM   = 32'h18;

   // field positions
   localparam int unsigned CTRL_EN_BIT  = 0;
   localparam int unsigned CTRL_IDX_LO  = 2;
   localparam int unsigned CTRL_IDX_W   = 3;
   localparam int unsigned CFG_WIDE_BIT = 5;
   localparam int unsigned CFG_CPOL_BIT = 11;
   localparam int unsigned CFG_CPHA_BIT = 12;
   localparam int unsigned TIM_DLY_LO   = 6;

   // sample-delay codes
   localparam logic [1:0] DLY_NOMINAL = 2'd1;
   localparam logic [1:0] DLY_LATE    = 2'd2;

   typedef struct packed {
      logic cpol;
      logic cpha;
      logic wide;
   } spi_mode_t;

endpackage

// File: rtl/spi_host_csmux.sv
module spi_host_csmux #(
   parameter int unsigned NUM_CS = 8,
   parameter int unsigned IDX_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_en,
   input  logic [IDX_W-1:0] cs_idx,
   output logic [NUM_CS-1:0] cs_n
);

   initial assert ((1 << IDX_W) >= NUM_CS)
      else $fatal(1, "select index too narrow for NUM_CS");

   for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
      assign cs_n[g] = ~(cs_en && (cs_idx == IDX_W'(g)));
   end

   // R2: with the assert bit clear no line may be low
   assert_cs_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_en |-> (&cs_n));

   // R2: never more than one peripheral selected
   assert_cs_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cs_n) <= 1);

endmodule

// File: rtl/spi_host_shift.sv
module spi_host_shift
   import spi_host_pkg::*;
#(
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned NARROW_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] tx_word,
   input  spi_mode_t         mode,
   input  logic              late_sample,
   input  logic              sck_tick,
   input  logic              miso,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] rx_word,
   output logic              sck,
   output logic              mosi
);

   localparam int unsigned CNT_W    = $clog2(2 * WORD_W);
   localparam int unsigned NARROW_S = WORD_W - NARROW_W;
   localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(2 * WORD_W - 1);
   localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(2 * NARROW_W - 1);

   initial assert (NARROW_W < WORD_W && NARROW_W > 0)
      else $fatal(1, "narrow word must be shorter than wide word");

   logic              busy_q, drain_q, pend_q;
   logic              sck_q, cpha_q, wide_q, late_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] tx_q, rx_q;

   logic tick_act, cap_edge, shift_edge, take_bit;
   logic [CNT_W-1:0] last_edge;

   always_comb begin
      last_edge  = wide_q ? LAST_WIDE : LAST_NARROW;
      tick_act   = busy_q && !drain_q && sck_tick;
      // even count = leading edge, odd count = trailing edge
      cap_edge   = cpha_q ? cnt_q[0] : !cnt_q[0];
      shift_edge = cpha_q ? (!cnt_q[0] && (cnt_q != '0)) : cnt_q[0];
      take_bit   = (tick_act && cap_edge && !late_q) || pend_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         drain_q <= 1'b0;
         pend_q  <= 1'b0;
         sck_q   <= 1'b0;
         cpha_q  <= 1'b0;
         wide_q  <= 1'b0;
         late_q  <= 1'b0;
         cnt_q   <= '0;
         tx_q    <= '0;
         rx_q    <= '0;
      end else if (start && !busy_q) begin
         busy_q  <= 1'b1;
         drain_q <= 1'b0;
         pend_q  <= 1'b0;
         sck_q   <= mode.cpol;
         cpha_q  <= mode.cpha;
         wide_q  <= mode.wide;
         late_q  <= late_sample;
         cnt_q   <= '0;
         rx_q    <= '0;
         tx_q    <= mode.wide ? tx_word : (tx_word << NARROW_S);
      end else if (busy_q) begin
         pend_q <= tick_act && cap_edge && late_q;
         if (take_bit) begin
            rx_q <= {rx_q[WORD_W-2:0], miso};
         end
         if (tick_act) begin
            sck_q <= ~sck_q;
            if (shift_edge) begin
               tx_q <= tx_q << 1;
            end
            if (cnt_q == last_edge) begin
               drain_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         if (drain_q && !pend_q) begin
            busy_q  <= 1'b0;
            drain_q <= 1'b0;
         end
      end
   end

   assign busy = busy_q;
   assign done = busy_q && drain_q && !pend_q;
   assign sck  = busy_q ? sck_q : mode.cpol;
   assign mosi = busy_q && tx_q[WORD_W-1];

   if (NARROW_S > 0) begin : g_rx_ext
      assign rx_word = wide_q ? rx_q : {{NARROW_S{1'b0}}, rx_q[NARROW_W-1:0]};
   end else begin : g_rx_plain
      assign rx_word = rx_q;
   end

   // R3: clock rests at the polarity level between exchanges
   assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sck == mode.cpol));

   // R4: data line quiet between exchanges
   assert_mosi_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mosi);

   // R4: an exchange ends only through completion
   assert_busy_ends_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done));

endmodule

// File: rtl/spi_host_csr.sv
module spi_host_csr
   import spi_host_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WORD_W = 16,
   parameter int unsigned IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              eng_busy,
   input  logic              eng_done,
   input  logic [WORD_W-1:0] eng_rx,
   output spi_mode_t         mode,
   output logic              late_sample,
   output logic              cs_en,
   output logic [IDX_W-1:0]  cs_idx,
   output logic              start,
   output logic [WORD_W-1:0] tx_word
);

   initial assert (WORD_W <= DATA_W && IDX_W <= CTRL_IDX_W && ADDR_W >= 5)
      else $fatal(1, "register layout does not fit the bus");

   logic              cs_en_q, cause_q;
   logic [IDX_W-1:0]  cs_idx_q;
   spi_mode_t         mode_q;
   logic [1:0]        dly_q;
   logic [WORD_W-1:0] dout_q, din_q;

   logic hit_ctrl, hit_cfg, hit_dout, hit_din, hit_cause, hit_tim;
   logic unused_wdata_bits;

   always_comb begin
      hit_ctrl  = bus_addr == ADDR_W'(OFS_CTRL);
      hit_cfg   = bus_addr == ADDR_W'(OFS_CFG);
      hit_dout  = bus_addr == ADDR_W'(OFS_DOUT);
      hit_din   = bus_addr == ADDR_W'(OFS_DIN);
      hit_cause = bus_addr == ADDR_W'(OFS_CAUSE);
      hit_tim   = bus_addr == ADDR_W'(OFS_TIM);
   end

   assign unused_wdata_bits = ^bus_wdata;
   assign start   = bus_wr && hit_dout && !eng_busy;
   assign tx_word = bus_wdata[WORD_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_en_q  <= 1'b0;
         cs_idx_q <= '0;
         mode_q   <= '0;
         dly_q    <= DLY_NOMINAL;
         dout_q   <= '0;
         din_q    <= '0;
         cause_q  <= 1'b0;
      end else begin
         if (bus_wr && hit_ctrl) begin
            cs_en_q  <= bus_wdata[CTRL_EN_BIT];
            cs_idx_q <= bus_wdata[CTRL_IDX_LO +: IDX_W];
         end
         if (bus_wr && hit_cfg) begin
            mode_q.cpol <= bus_wdata[CFG_CPOL_BIT];
            mode_q.cpha <= bus_wdata[CFG_CPHA_BIT];
            mode_q.wide <= bus_wdata[CFG_WIDE_BIT];
         end
         if (bus_wr && hit_tim) begin
            dly_q <= bus_wdata[TIM_DLY_LO +: 2];
         end
         if (start) begin
            dout_q <= bus_wdata[WORD_W-1:0];
         end
         if (eng_done) begin
            din_q   <= eng_rx;
            cause_q <= 1'b1;
         end else if (bus_wr && hit_cause) begin
            cause_q <= 1'b0;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_ctrl) begin
         bus_rdata[CTRL_EN_BIT]            = cs_en_q;
         bus_rdata[CTRL_IDX_LO +: IDX_W]   = cs_idx_q;
      end else if (hit_cfg) begin
         bus_rdata[CFG_CPOL_BIT] = mode_q.cpol;
         bus_rdata[CFG_CPHA_BIT] = mode_q.cpha;
         bus_rdata[CFG_WIDE_BIT] = mode_q.wide;
      end else if (hit_dout) begin
         bus_rdata[WORD_W-1:0] = dout_q;
      end else if (hit_din) begin
         bus_rdata[WORD_W-1:0] = din_q;
      end else if (hit_cause) begin
         bus_rdata[0] = cause_q;
      end else if (hit_tim) begin
         bus_rdata[TIM_DLY_LO +: 2] = dly_q;
      end
   end

   assign mode        = mode_q;
   assign late_sample = (dly_q == DLY_LATE);
   assign cs_en       = cs_en_q;
   assign cs_idx      = cs_idx_q;

   // R6: completion always raises the cause flag
   assert_cause_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> cause_q);

   // R7: a data-out write during an exchange leaves the held word alone
   assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_dout && eng_busy) |=> $stable(dout_q));

endmodule

// File: rtl/spi_host_top.sv
module spi_host_top
   import spi_host_pkg::*;
#(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned NARROW_W = 8,
   parameter int unsigned NUM_CS   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              sck_tick,
   input  logic              miso,
   output logic              sck,
   output logic              mosi,
   output logic [NUM_CS-1:0] cs_n
);

   localparam int unsigned IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

   initial assert (NUM_CS >= 1 && NUM_CS <= (1 << CTRL_IDX_W))
      else $fatal(1, "NUM_CS exceeds the select field");

   spi_mode_t         mode;
   logic              late_sample, cs_en, start, busy, done;
   logic [IDX_W-1:0]  cs_idx;
   logic [WORD_W-1:0] tx_word, rx_word;

   spi_host_csr #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W), .IDX_W(IDX_W)
   ) u_csr (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .eng_busy(busy), .eng_done(done), .eng_rx(rx_word),
      .mode(mode), .late_sample(late_sample),
      .cs_en(cs_en), .cs_idx(cs_idx),
      .start(start), .tx_word(tx_word)
   );

   spi_host_shift #(
      .WORD_W(WORD_W), .NARROW_W(NARROW_W)
   ) u_shift (
      .clk(clk), .rst_n(rst_n),
      .start(start), .tx_word(tx_word), .mode(mode),
      .late_sample(late_sample), .sck_tick(sck_tick), .miso(miso),
      .busy(busy), .done(done), .rx_word(rx_word),
      .sck(sck), .mosi(mosi)
   );

   spi_host_csmux #(
      .NUM_CS(NUM_CS), .IDX_W(IDX_W)
   ) u_csmux (
      .clk(clk), .rst_n(rst_n),
      .cs_en(cs_en), .cs_idx(cs_idx), .cs_n(cs_n)
   );

endmodule

// File: tb/tb_spi_host_top.sv
module tb_spi_host_top;

   localparam int ADDR_W = 5;
   localparam int DATA_W = 32;
   localparam int NUM_CS = 8;

   localparam logic [4:0] A_CTRL = 5'h00, A_CFG = 5'h04, A_DOUT = 5'h08,
                          A_DIN = 5'h0C, A_CAUSE = 5'h10, A_TIM = 5'h18,
                          A_HOLE = 5'h14;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic bus_wr = 1'b0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic sck_tick = 1'b0;
   logic miso = 1'b0;
   logic sck, mosi;
   logic [NUM_CS-1:0] cs_n;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   spi_host_top dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_tick(sck_tick),
      .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   // one exchange with a peripheral model; flip inverts MISO right after each capture edge
   task automatic xfer(input bit cpol, input bit cpha, input bit wide, input bit late,
                       input bit flip, input bit midwrite,
                       input logic [15:0] txw, input logic [15:0] mw);
      int n, issued, seen, sent;
      logic prev;
      logic [15:0] srx, mask;
      logic [31:0] v, exp_rx;
      bit leading;
      n = wide ? 16 : 8;
      mask = wide ? 16'hFFFF : 16'h00FF;
      wr(A_CFG, (32'(cpol) << 11) | (32'(cpha) << 12) | (32'(wide) << 5));
      wr(A_TIM, late ? 32'h80 : 32'h40);
      wr(A_CAUSE, 32'h0);
      chk("R3 idle sck level", {31'b0, sck}, {31'b0, cpol});
      issued = 0; seen = 0; sent = 0; srx = '0; prev = sck;
      if (!cpha) begin miso = mw[n-1]; sent = 1; end else miso = 1'b0;
      wr(A_DOUT, {16'h0, txw});
      for (int i = 0; i < 4 * n + 10; i++) begin
         sck_tick = (i % 2 == 0) && (issued < 2 * n);
         if (sck_tick) issued++;
         if (midwrite && i == 5) begin
            bus_addr = A_DOUT; bus_wdata = {16'h0, ~txw}; bus_wr = 1'b1;
         end
         @(negedge clk);
         sck_tick = 1'b0; bus_wr = 1'b0;
         if (sck !== prev) begin
            leading = (seen % 2 == 0);
            seen++;
            prev = sck;
            if (cpha ? !leading : leading) begin
               srx = {srx[14:0], mosi};
               if (flip) miso = ~miso;
            end else if (sent < n) begin
               miso = mw[n-1-sent];
               sent++;
            end
         end
      end
      chk("R4 edge count", 32'(seen), 32'(2 * n));
      chk("R3 sck back at idle", {31'b0, sck}, {31'b0, cpol});
      chk("R4 mosi MSB-first word", {16'h0, srx & mask}, {16'h0, txw & mask});
      chk("R4 mosi low after exchange", {31'b0, mosi}, 32'h0);
      rd(A_CAUSE, v);
      chk("R6 cause set", v, 32'h1);
      exp_rx = (late && flip) ? {16'h0, ~mw & mask} : {16'h0, mw & mask};
      rd(A_DIN, v);
      chk(late ? "R8 R5 data-in late sample" : "R8 R5 data-in nominal sample", v, exp_rx);
      if (midwrite) begin
         rd(A_DOUT, v);
         chk("R7 data-out readback unchanged", v, {16'h0, txw});
      end
   endtask

   initial begin
      logic [31:0] v;
      logic [15:0] t, m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 cs_n", {24'h0, cs_n}, 32'h000000FF);
      chk("R1 sck", {31'b0, sck}, 32'h0);
      chk("R1 mosi", {31'b0, mosi}, 32'h0);
      rd(A_CTRL, v);  chk("R1 control", v, 32'h0);
      rd(A_CFG, v);   chk("R1 config", v, 32'h0);
      rd(A_DOUT, v);  chk("R1 data-out", v, 32'h0);
      rd(A_DIN, v);   chk("R1 data-in", v, 32'h0);
      rd(A_CAUSE, v); chk("R1 cause", v, 32'h0);
      rd(A_TIM, v);   chk("R1 timing", v, 32'h40);

      // R9 unused bits
      rd(A_HOLE, v);  chk("R9 unmapped offset", v, 32'h0);
      wr(A_CFG, 32'hFFFFFFFF); rd(A_CFG, v); chk("R9 config mask", v, 32'h00001820);
      wr(A_TIM, 32'hFFFFFFFF); rd(A_TIM, v); chk("R9 timing mask", v, 32'h000000C0);
      wr(A_CTRL, 32'hFFFFFFFE); rd(A_CTRL, v); chk("R9 control mask", v, 32'h0000001C);
      chk("R2 no select with bit0 clear", {24'h0, cs_n}, 32'hFF);
      wr(A_CFG, 32'h0); wr(A_TIM, 32'h40);

      // R2 select sweep
      for (int k = 0; k < NUM_CS; k++) begin
         wr(A_CTRL, (32'(k) << 2) | 32'h1);
         chk("R2 one select low", {24'h0, cs_n}, {24'h0, ~(8'h01 << k)});
         rd(A_CTRL, v);
         chk("R2 control readback", v, (32'(k) << 2) | 32'h1);
      end
      wr(A_CTRL, 32'h0000000C);
      chk("R2 release all", {24'h0, cs_n}, 32'hFF);
      wr(A_CTRL, 32'h00000015);

      // all modes, both widths, both sample points
      for (int c = 0; c < 16; c++) begin
         t = 16'hA53C ^ (16'(c) * 16'h1357);
         m = {t[6:0], t[15:7]} ^ 16'h5A0F;
         xfer(c[0], c[1], c[2], c[3], 1'b0, 1'b0, t, m);
      end

      // R8 sample point against a MISO that flips right after each capture edge
      for (int c = 0; c < 16; c++) begin
         t = 16'h3C96 + 16'(c * 77);
         m = 16'hC3E1 ^ 16'(c * 291);
         xfer(c[0], c[1], c[2], c[3], 1'b1, 1'b0, t, m);
      end

      // R7 write during an exchange
      xfer(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'hBEEF, 16'h1234);
      xfer(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h71C3, 16'h00A6);

      // R5 narrow mode ignores upper byte of the written word
      xfer(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFF5A, 16'hFFC3);

      // R6 nonzero write clears the cause
      wr(A_CAUSE, 32'h5);
      rd(A_CAUSE, v); chk("R6 cause cleared", v, 32'h0);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule